// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block produces the per-beat source and destination addresses for one DMA channel and counts the transfers in a block. Software first loads a source address, a destination address, a 17-bit control word and a 12-bit block size. It then pulses `start`. While the block runs, each accepted beat (`beat_ok`) moves both addresses by their own side's transfer width, in that side's step direction. It also counts one transfer in source-width units. Each side has a burst counter, and it pulses when that side completes a burst.

The channel is a four-state machine:

- IDLE is the state after reset or after a load.
- RUN is the state while beats are being taken.
- DONE is the state after the block completes.
- FAULT is the state after a rejected start.

The transitions are:

- LOAD: a load from IDLE, DONE or FAULT goes to IDLE.
- LAUNCH: a start with legal codes, aligned addresses and a nonzero size goes to RUN.
- EMPTY: a start with a size of zero goes straight to DONE.
- REJECT: a start with a reserved code or a misaligned address goes to FAULT.
- FINISH: the last beat moves the channel from RUN to DONE.

A start from DONE or FAULT is evaluated like a start from IDLE. It uses the current addresses, so a finished block can be chained into another one.

Control word layout:

| Bits | Field | Codes |
|---|---|---|
| [0] | completion interrupt enable | 1 = enabled |
| [3:1] | destination width | 0..3 = 1, 2, 4, 8 bytes |
| [6:4] | source width | 0..3 = 1, 2, 4, 8 bytes |
| [8:7] | destination step | 0 = increment, 1 = decrement, 2 = hold |
| [10:9] | source step | 0 = increment, 1 = decrement, 2 = hold |
| [13:11] | destination burst | 0..3 = 1, 4, 8, 16 beats |
| [16:14] | source burst | 0..3 = 1, 4, 8, 16 beats |

Top module: `dma_addr_engine`

## Requirements
- R1: After reset, both addresses and `xfer_cnt` are 0; `active`, `done`, `fault`, `irq` and both burst pulses are 0.
- R2: `cfg_load` outside RUN captures the addresses, control word and size, returns to IDLE, clears `done`/`fault` and zeroes `xfer_cnt` after the edge; `cfg_load` during RUN is ignored (addresses keep following the running block). When `cfg_load` and `start` coincide the load wins.
- R3: A start outside RUN with legal codes, aligned addresses and nonzero size raises `active` after the edge with `xfer_cnt` = 0.
- R4: Each beat accepted in RUN changes each address by its width in bytes (control width code 0,1,2,3 = 1,2,4,8 bytes; source [6:4], destination [3:1]). The direction is set by the step code (0 increment, 1 decrement, 2 hold; source [10:9], destination [8:7]). Without a beat, or outside RUN, `beat_ok` leaves both addresses unchanged.
- R5: `xfer_cnt` counts accepted beats. The edge that accepts beat number `size` drops `active` and sets `done`.
- R6: A start with size 0 (and otherwise legal) sets `done` after the edge without ever raising `active` or changing addresses.
- R7: A start whose source or destination address has a nonzero bit below its width alignment sets `fault` and does not raise `active`.
- R8: A start with any reserved code (a width code of 4 to 7, a step code of 3, or a burst code of 4 to 7) sets `fault` and does not raise `active`.
- R9: Each side's burst pulse is high for one cycle after every N-th beat of that side since the last start. Burst code 0,1,2,3 gives N = 1,4,8,16 (source [16:14], destination [13:11]).
- R10: When control bit 0 is 1, `irq` is high for the one cycle after the edge that enters DONE (including the size 0 case). When bit 0 is 0, `irq` stays low.
- R11: `start` during RUN is ignored. A start from DONE continues from the current addresses with the count restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load the configuration below |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_ctl | input | 17 | Control word (layout above) |
| cfg_size | input | CW | Block size in source-width beats |
| start | input | 1 | Begin a block |
| beat_ok | input | 1 | One beat accepted this cycle |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| xfer_cnt | output | CW | Beats taken in the current block |
| active | output | 1 | Channel in RUN |
| done | output | 1 | Block completed |
| fault | output | 1 | Start rejected |
| irq | output | 1 | One-cycle completion interrupt |
| src_burst_end | output | 1 | Source burst finished |
| dst_burst_end | output | 1 | Destination burst finished |

## Verification
The address path is tested with four mixes:

- Both sides incrementing at unequal widths, which catches a side taking the other side's stride.
- A decrementing 8-byte source against a held 2-byte destination, which separates the sign and the hold.
- Gapped beats, which show that idle cycles do not step.
- A 40-beat block with 16-beat bursts, which exposes burst counters that wrap at the wrong point.

Separate starts with a misaligned address on each side, with each kind of reserved code and with size 0 distinguish the FAULT, DONE and RUN exits from IDLE. Loads and starts issued in the middle of a run show whether the running block is protected.

// File: rtl/dae_pkg.sv
package dae_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } dae_state_e;

    localparam logic [1:0] STEP_INC  = 2'd0;
    localparam logic [1:0] STEP_DEC  = 2'd1;
    localparam logic [1:0] STEP_HOLD = 2'd2;

    // Packed so that field bit positions match the control word layout.
    typedef struct packed {
        logic [2:0] src_burst;   // [16:14]
        logic [2:0] dst_burst;   // [13:11]
        logic [1:0] src_step;    // [10:9]
        logic [1:0] dst_step;    // [8:7]
        logic [2:0] src_width;   // [6:4]
        logic [2:0] dst_width;   // [3:1]
        logic       irq_en;      // [0]
    } dae_ctl_t;

    localparam int CTL_W = $bits(dae_ctl_t);

    function automatic logic code_legal(input logic [2:0] width,
                                        input logic [1:0] step,
                                        input logic [2:0] burst);
        return !width[2] && (step != 2'd3) && !burst[2];
    endfunction

endpackage

// File: rtl/dae_addr_side.sv
module dae_addr_side #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic [2:0]    wcode,
    input  logic [1:0]    mode,
    output logic [AW-1:0] addr,
    output logic          aligned
);
    import dae_pkg::*;

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_q;
    logic [AW-1:0] stride;

    always_comb begin
        unique case (wcode)
            3'd0:    stride = ONE;
            3'd1:    stride = ONE << 1;
            3'd2:    stride = ONE << 2;
            default: stride = ONE << 3;
        endcase
    end

    assign aligned = ((addr_q & (stride - ONE)) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_en) begin
            addr_q <= load_val;
        end else if (adv) begin
            unique case (mode)
                STEP_INC: addr_q <= addr_q + stride;
                STEP_DEC: addr_q <= addr_q - stride;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dae_burst_tick.sv
module dae_burst_tick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [2:0] code,
    output logic       pulse
);
    logic [3:0] cnt_q;
    logic [3:0] last;

    always_comb begin
        unique case (code)
            3'd0:    last = 4'd0;
            3'd1:    last = 4'd3;
            3'd2:    last = 4'd7;
            default: last = 4'd15;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (adv) begin
                if (cnt_q == last) begin
                    cnt_q <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 4'd1;
                end
            end
        end
    end

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine #(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [16:0]   cfg_ctl,
    input  logic [CW-1:0] cfg_size,
    input  logic          start,
    input  logic          beat_ok,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] xfer_cnt,
    output logic          active,
    output logic          done,
    output logic          fault,
    output logic          irq,
    output logic          src_burst_end,
    output logic          dst_burst_end
);
    import dae_pkg::*;

    localparam int SIDES = 2;  // 0 = source, 1 = destination

    dae_state_e    state_q, state_d;
    dae_ctl_t      ctl_q;
    logic [CW-1:0] size_q;
    logic [CW-1:0] cnt_q;
    logic          irq_q;

    logic load_ok, launch, adv, last_beat, codes_ok, addrs_ok, enter_done;

    logic [AW-1:0] side_load [SIDES];
    logic [AW-1:0] side_addr [SIDES];
    logic [2:0]    side_w    [SIDES];
    logic [1:0]    side_m    [SIDES];
    logic [2:0]    side_b    [SIDES];
    logic [SIDES-1:0] side_al;
    logic [SIDES-1:0] side_pulse;

    assign load_ok   = cfg_load && (state_q != ST_RUN);
    assign launch    = start && !cfg_load && (state_q != ST_RUN);
    assign adv       = (state_q == ST_RUN) && beat_ok;
    assign last_beat = adv && (cnt_q == size_q - {{(CW-1){1'b0}}, 1'b1});
    assign codes_ok  = code_legal(ctl_q.src_width, ctl_q.src_step, ctl_q.src_burst)
                    && code_legal(ctl_q.dst_width, ctl_q.dst_step, ctl_q.dst_burst);
    assign addrs_ok  = &side_al;

    assign side_load[0] = cfg_src;
    assign side_load[1] = cfg_dst;
    assign side_w[0] = ctl_q.src_width;
    assign side_w[1] = ctl_q.dst_width;
    assign side_m[0] = ctl_q.src_step;
    assign side_m[1] = ctl_q.dst_step;
    assign side_b[0] = ctl_q.src_burst;
    assign side_b[1] = ctl_q.dst_burst;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dae_addr_side #(.AW(AW)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_ok),
            .load_val (side_load[s]),
            .adv      (adv),
            .wcode    (side_w[s]),
            .mode     (side_m[s]),
            .addr     (side_addr[s]),
            .aligned  (side_al[s])
        );
        dae_burst_tick u_burst (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (launch),
            .adv   (adv),
            .code  (side_b[s]),
            .pulse (side_pulse[s])
        );
    end

    // Configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            size_q <= '0;
        end else if (load_ok) begin
            ctl_q  <= dae_ctl_t'(cfg_ctl);
            size_q <= cfg_size;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (last_beat) state_d = ST_DONE;              // FINISH
            end
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (load_ok)                    state_d = ST_IDLE;  // LOAD
                else if (start) begin
                    if (!codes_ok || !addrs_ok) state_d = ST_FAULT; // REJECT
                    else if (size_q == '0)      state_d = ST_DONE;  // EMPTY
                    else                        state_d = ST_RUN;   // LAUNCH
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign enter_done = last_beat || (launch && (state_d == ST_DONE));

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= ctl_q.irq_en && enter_done;
            if (load_ok || launch) cnt_q <= '0;
            else if (adv)          cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    assign src_addr      = side_addr[0];
    assign dst_addr      = side_addr[1];
    assign xfer_cnt      = cnt_q;
    assign active        = (state_q == ST_RUN);
    assign done          = (state_q == ST_DONE);
    assign fault         = (state_q == ST_FAULT);
    assign irq           = irq_q;
    assign src_burst_end = side_pulse[0];
    assign dst_burst_end = side_pulse[1];

endmodule

// File: rtl/dae_checker.sv
module dae_checker #(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_load,
    input logic          start,
    input logic          beat_ok,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr,
    input logic [CW-1:0] xfer_cnt,
    input logic          active,
    input logic          done,
    input logic          fault,
    input logic          irq,
    input logic          src_burst_end,
    input logic          dst_burst_end
);
    // R4
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !beat_ok |=> $stable(src_addr) && $stable(dst_addr));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !cfg_load |=> $stable(src_addr) && $stable(dst_addr));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && beat_ok |=> (xfer_cnt == $past(xfer_cnt) + 1'b1));

    // R3
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start) && (xfer_cnt == '0));

    // R7
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(start));

    // R10
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    // R9
    src_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_burst_end |-> $past(active && beat_ok));

    // R9
    dst_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_burst_end |-> $past(active && beat_ok));

endmodule

bind dma_addr_engine dae_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .start         (start),
    .beat_ok       (beat_ok),
    .src_addr      (src_addr),
    .dst_addr      (dst_addr),
    .xfer_cnt      (xfer_cnt),
    .active        (active),
    .done          (done),
    .fault         (fault),
    .irq           (irq),
    .src_burst_end (src_burst_end),
    .dst_burst_end (dst_burst_end)
);

// File: tb/dma_addr_engine_tb_top.sv
`timescale 1ns/1ps
module dma_addr_engine_tb_top;
    localparam int AW = 32;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [16:0] cfg_ctl = '0;
    logic [CW-1:0] cfg_size = '0;
    logic start = 1'b0, beat_ok = 1'b0;
    logic [AW-1:0] src_addr, dst_addr;
    logic [CW-1:0] xfer_cnt;
    logic active, done, fault, irq, src_burst_end, dst_burst_end;

    always #2.5 clk = ~clk;

    dma_addr_engine #(.AW(AW), .CW(CW)) dut_i (.*);

    int n_checks = 0, n_fail = 0;
    string scen = "R1";

    // Reference model state: 0 idle, 1 run, 2 done, 3 fault
    int m_st = 0, m_cnt = 0, m_size = 0, m_bs = 0, m_bd = 0;
    logic [31:0] m_src = 0, m_dst = 0;
    logic [16:0] m_ctl = 0;
    bit m_irq = 0, m_ps = 0, m_pd = 0;

    function automatic logic [16:0] mk_ctl(int ien, int dw, int sw, int dstep,
                                           int sstep, int db, int sb);
        return {3'(sb), 3'(db), 2'(sstep), 2'(dstep), 3'(sw), 3'(dw), 1'(ien)};
    endfunction

    function automatic int blen(int code);
        return (code == 0) ? 1 : (4 << (code - 1));
    endfunction

    function automatic logic [31:0] stepped(logic [31:0] a, int w, int mode);
        if (mode == 0) return a + (32'd1 << w);
        if (mode == 1) return a - (32'd1 << w);
        return a;
    endfunction

    task automatic model_step();
        int sw, dw, ss, ds, sb, db;
        bit bad;
        sw = int'(m_ctl[6:4]); dw = int'(m_ctl[3:1]);
        ss = int'(m_ctl[10:9]); ds = int'(m_ctl[8:7]);
        sb = int'(m_ctl[16:14]); db = int'(m_ctl[13:11]);
        m_irq = 0; m_ps = 0; m_pd = 0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_size = 0; m_bs = 0; m_bd = 0;
            m_src = 0; m_dst = 0; m_ctl = 0;
            return;
        end
        if (m_st == 1) begin
            if (beat_ok) begin
                m_src = stepped(m_src, sw, ss);
                m_dst = stepped(m_dst, dw, ds);
                m_cnt++;
                m_bs++; if (m_bs == blen(sb)) begin m_bs = 0; m_ps = 1; end
                m_bd++; if (m_bd == blen(db)) begin m_bd = 0; m_pd = 1; end
                if (m_cnt == m_size) begin m_st = 2; m_irq = m_ctl[0]; end
            end
        end else if (cfg_load) begin
            m_src = cfg_src; m_dst = cfg_dst; m_ctl = cfg_ctl;
            m_size = int'(cfg_size); m_st = 0; m_cnt = 0;
        end else if (start) begin
            m_bs = 0; m_bd = 0; m_cnt = 0;
            bad = (sw > 3) || (dw > 3) || (ss == 3) || (ds == 3) || (sb > 3) || (db > 3);
            if (!bad) bad = ((m_src % (32'd1 << sw)) != 0) || ((m_dst % (32'd1 << dw)) != 0);
            if (bad)              m_st = 3;
            else if (m_size == 0) begin m_st = 2; m_irq = m_ctl[0]; end
            else                  m_st = 1;
        end
    endtask

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (scenario %s) at %0t: actual %0h expected %0h",
                     tag, scen, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk(src_addr == m_src, "R4 src_addr", src_addr, m_src);
        chk(dst_addr == m_dst, "R4 dst_addr", dst_addr, m_dst);
        chk(int'(xfer_cnt) == m_cnt, "R5 xfer_cnt", xfer_cnt, m_cnt);
        chk(active == (m_st == 1), "R3 active", active, m_st == 1);
        chk(done == (m_st == 2), "R5 done", done, m_st == 2);
        chk(fault == (m_st == 3), "R7 fault", fault, m_st == 3);
        chk(irq == m_irq, "R10 irq", irq, m_irq);
        chk(src_burst_end == m_ps, "R9 src_burst_end", src_burst_end, m_ps);
        chk(dst_burst_end == m_pd, "R9 dst_burst_end", dst_burst_end, m_pd);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_load(logic [31:0] s, logic [31:0] d, logic [16:0] c, int sz);
        cfg_src = s; cfg_dst = d; cfg_ctl = c; cfg_size = CW'(sz);
        cfg_load = 1; tick(); cfg_load = 0;
    endtask

    task automatic do_start();
        start = 1; tick(); start = 0;
    endtask

    task automatic beats(int n, int gap);
        for (int i = 0; i < n; i++) begin
            beat_ok = 1; tick(); beat_ok = 0;
            for (int g = 0; g < gap; g++) tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired in scenario %s", scen);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        scen = "R1";
        repeat (3) tick();
        rst_n = 1; tick(); tick();

        // R2 R3 R4 R5 R9 R10: two increments, unequal widths, gapped beats
        scen = "R2";
        do_load(32'h1000, 32'h2000, mk_ctl(1, 0, 2, 0, 0, 1, 1), 10);
        tick();
        do_start();
        beats(10, 1);
        tick(); tick();

        // R4 R9: decrementing 8-byte source, held 2-byte destination
        scen = "R4";
        do_load(32'h8000, 32'h4002, mk_ctl(1, 1, 3, 2, 1, 3, 0), 5);
        do_start();
        beats(5, 0);
        tick();
        // R4: beat_ok outside RUN has no effect
        beats(3, 0);
        tick();

        // R11 R2: load and start while running are ignored
        scen = "R11";
        do_load(32'h100, 32'h200, mk_ctl(0, 2, 2, 0, 0, 0, 0), 6);
        do_start();
        beats(2, 0);
        cfg_src = 32'hDEAD0; cfg_dst = 32'hBEEF0; cfg_size = 12'd1;
        cfg_load = 1; beat_ok = 1; tick(); cfg_load = 0; beat_ok = 0;
        start = 1; tick(); start = 0;
        beats(3, 0);
        tick();
        // R11: restart from DONE continues the addresses
        do_start();
        beats(6, 0);
        tick();

        // R2: load and start in one cycle, load wins
        scen = "R2";
        cfg_src = 32'h40; cfg_dst = 32'h80; cfg_ctl = mk_ctl(1, 2, 2, 0, 0, 0, 0);
        cfg_size = 12'd2; cfg_load = 1; start = 1; tick(); cfg_load = 0; start = 0;
        tick();

        // R6 R10: size zero completes at once, with and without interrupt
        scen = "R6";
        do_load(32'h300, 32'h400, mk_ctl(1, 0, 0, 0, 0, 0, 0), 0);
        do_start(); tick();
        do_load(32'h300, 32'h400, mk_ctl(0, 0, 0, 0, 0, 0, 0), 0);
        do_start(); tick();
        scen = "R10";
        do_load(32'h10, 32'h20, mk_ctl(0, 0, 0, 0, 0, 0, 0), 3);
        do_start(); beats(3, 0); tick();

        // R7: misaligned source, then misaligned destination
        scen = "R7";
        do_load(32'h1002, 32'h2000, mk_ctl(1, 0, 2, 0, 0, 0, 0), 4);
        do_start(); beats(1, 0); tick();
        do_load(32'h1000, 32'h2004, mk_ctl(1, 3, 0, 0, 0, 0, 0), 4);
        do_start(); tick();
        do_load(32'h1000, 32'h2008, mk_ctl(1, 3, 0, 0, 0, 0, 0), 1);
        do_start(); beats(1, 0); tick();

        // R8: reserved width, step and burst codes
        scen = "R8";
        do_load(32'h0, 32'h0, mk_ctl(0, 0, 4, 0, 0, 0, 0), 2);
        do_start(); tick();
        do_load(32'h0, 32'h0, mk_ctl(0, 0, 0, 3, 0, 0, 0), 2);
        do_start(); tick();
        do_load(32'h0, 32'h0, mk_ctl(0, 0, 0, 0, 0, 0, 5), 2);
        do_start(); tick();

        // R9: long block with 16-beat source bursts and 8-beat destination
        scen = "R9";
        do_load(32'h10000, 32'h20000, mk_ctl(1, 2, 1, 0, 0, 2, 3), 40);
        do_start();
        beats(20, 0);
        beats(20, 2);
        tick(); tick();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule